// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

A counter of configurable width with a companion reload register. Each count step comes from one of two sources. The first is a prescaled tick that fires once every PRESCALE system clocks, 12 by default. The second is a rising edge on an external count pin, which passes through a flop synchronizer and an edge detector first. A run enable gates every step.

A direction-enable input picks the mode. With it clear, the counter only counts up. When it passes the all-ones value it reloads from the reload register and raises an overflow flag. With it set, an external direction pin picks the direction. Counting up behaves as in the plain mode. Counting down, a step taken while the count equals the reload value is an underflow: it loads all-ones and raises the same flag.

In up/down mode a separate toggle bit inverts on every overflow or underflow. It never raises the flag, and it serves as a seventeenth (top) count bit. The flag is a sticky interrupt request that software clears with a strobe. A register port writes the count and the reload value.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset, count, reload, ovf_flag and toggle are all zero.
- R2: With src_sel=0 and run_en=1, the count advances by one every PRESCALE clocks, counted from the clock edge at which run_en was first seen high. The prescaler is held at zero while run_en=0 or src_sel=1.
- R3: With src_sel=1, each 0-to-1 change of cnt_pin advances the count exactly once, on the third rising clock edge after the pin rose. A pin held high gives no further steps.
- R4: While run_en=0 the count does not change, except through a register write.
- R5: With dir_en=0 the counter counts up whatever dir_pin is. A step from all-ones loads the reload value and sets ovf_flag.
- R6: With dir_en=1 and dir_pin=1 the counter counts up. A step from all-ones loads the reload value and sets ovf_flag.
- R7: With dir_en=1 and dir_pin=0 the counter counts down. A step taken while the count equals the reload value loads all-ones and sets ovf_flag. Otherwise a step subtracts one.
- R8: toggle inverts on every overflow or underflow that occurs while dir_en=1. It is unchanged by events that occur while dir_en=0.
- R9: ovf_flag stays set until a cycle with flag_clr=1 and no new event. A clear in the same cycle as an event leaves the flag set.
- R10: wr_cnt=1 loads wr_data into the count on the next edge, and this wins over a count step in the same cycle; such a step raises no event. wr_rld=1 loads wr_data into the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Enables counting |
| src_sel | input | 1 | 0: prescaled tick, 1: external pin edges |
| dir_en | input | 1 | 1: up/down mode, 0: up-only auto-reload |
| dir_pin | input | 1 | Direction in up/down mode (1 up, 0 down) |
| cnt_pin | input | 1 | External count pin, asynchronous |
| wr_cnt | input | 1 | Write strobe for the count |
| wr_rld | input | 1 | Write strobe for the reload register |
| wr_data | input | WIDTH | Write data |
| flag_clr | input | 1 | Clear strobe for ovf_flag |
| count | output | WIDTH | Current count |
| reload | output | WIDTH | Reload register |
| ovf_flag | output | 1 | Sticky overflow/underflow interrupt request |
| toggle | output | 1 | Inverts on each event in up/down mode |

## Verification
The bench builds the timer with WIDTH=8 and the default PRESCALE=12, so all-ones is 0xFF. Wraps in both directions are then a few pin pulses away after a count write, and the divide-by-12 tick can be checked against exact edge counts. The external pin is pulsed one clock at a time. Because the edge reaches the count on a known edge, a flag clear and a count write can be placed in the same cycle as a wrap event. That exercises the priority rules of R9 and R10.

// File: rtl/tmr_pkg.sv
// Shared types for the auto-reload timer.
// Assumes: nothing beyond IEEE 1800-2017.
package tmr_pkg;
    // Count direction chosen for one step.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr_tick_gen.sv
// Produces one-cycle count enables from either a divide-by-PRESCALE
// tick or synchronized rising edges of an asynchronous pin.
// Assumes: PRESCALE >= 2, SYNC_STAGES >= 1, pin pulses last at least one clock.
module tmr_tick_gen #(
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic src_sel,
    input  logic cnt_pin,
    output logic tick
);
    localparam int PW = $clog2(PRESCALE);

    logic [PW-1:0]          pre_q;
    logic                   pre_hit;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   pin_rise;

    assign pre_hit = (pre_q == PW'(PRESCALE - 1));

    // Prescale divider, held at zero when the internal tick is not in use.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || src_sel || pre_hit)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // Synchronizer chain for the external count pin.
    genvar i;
    generate
        for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= cnt_pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign pin_rise = sync_q[SYNC_STAGES-1] & ~last_q;
    assign tick     = run_en & (src_sel ? pin_rise : pre_hit);
endmodule

// File: rtl/tmr_core.sv
// Count and reload registers with wrap detection in both directions.
// Up wraps at all-ones to the reload value. Down wraps at the reload
// value to all-ones. A count write overrides a step.
// Assumes: tick is a single-cycle enable.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  dir_e             dir,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] reload,
    output logic             wrap_evt
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic             at_wrap;
    logic [WIDTH-1:0] step_val;

    // Next value for one step in the chosen direction.
    always_comb begin
        if (dir == DIR_UP) begin
            at_wrap  = (count == ALL_ONES);
            step_val = at_wrap ? reload : count + 1'b1;
        end else begin
            at_wrap  = (count == reload);
            step_val = at_wrap ? ALL_ONES : count - 1'b1;
        end
    end

    assign wrap_evt = tick & ~wr_cnt & at_wrap;

    // Count register: a write first, then a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (wr_cnt) count <= wr_data;
        else if (tick)   count <= step_val;
    end

    // Reload register, written only through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (wr_rld) reload <= wr_data;
    end
endmodule

// File: rtl/tmr_flags.sv
// Sticky interrupt flag and the extra toggle bit for up/down mode.
// Assumes: wrap_evt is a single-cycle pulse.
module tmr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_evt,
    input  logic dir_en,
    input  logic flag_clr,
    output logic ovf_flag,
    output logic toggle
);
    // Flag: an event sets it, and setting wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= 1'b0;
        else        ovf_flag <= wrap_evt | (ovf_flag & ~flag_clr);
    end

    // Toggle: inverts on each event seen in up/down mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  toggle <= 1'b0;
        else if (wrap_evt && dir_en) toggle <= ~toggle;
    end
endmodule

// File: rtl/updown_reload_timer.sv
// Top of the up/down auto-reload timer: tick source, counter core, flags.
// Assumes: all inputs other than cnt_pin are synchronous to clk.
module updown_reload_timer
    import tmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int PRESCALE    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             src_sel,
    input  logic             dir_en,
    input  logic             dir_pin,
    input  logic             cnt_pin,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] reload,
    output logic             ovf_flag,
    output logic             toggle
);
    logic tick;
    logic wrap_evt;
    dir_e dir;

    // Direction: up unless up/down mode is on and the pin asks for down.
    assign dir = (!dir_en || dir_pin) ? DIR_UP : DIR_DOWN;

    tmr_tick_gen #(
        .PRESCALE(PRESCALE),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
        .cnt_pin(cnt_pin), .tick(tick)
    );

    tmr_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dir(dir),
        .wr_cnt(wr_cnt), .wr_rld(wr_rld), .wr_data(wr_data),
        .count(count), .reload(reload), .wrap_evt(wrap_evt)
    );

    tmr_flags u_flags (
        .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .dir_en(dir_en),
        .flag_clr(flag_clr), .ovf_flag(ovf_flag), .toggle(toggle)
    );
endmodule

// File: rtl/tmr_checker.sv
// Temporal checks on the timer ports, bound to every instance of the top.
// Assumes: synchronous active-low reset.
module tmr_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             dir_en,
    input logic             dir_pin,
    input logic             wr_cnt,
    input logic [WIDTH-1:0] wr_data,
    input logic             flag_clr,
    input logic [WIDTH-1:0] count,
    input logic [WIDTH-1:0] reload,
    input logic             ovf_flag,
    input logic             toggle
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    // R4: a stopped timer keeps its count.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_cnt) |=> $stable(count));

    // R5: up-only mode below all-ones moves by zero or plus one.
    assert_up_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !dir_en && !wr_cnt && count != ALL_ONES) |=>
        (count == $past(count) || count == $past(count) + 1'b1));

    // R7: counting down away from the reload value moves by zero or minus one.
    assert_down_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && dir_en && !dir_pin && !wr_cnt && count != reload) |=>
        (count == $past(count) || count == $past(count) - 1'b1));

    // R8: in up-only mode the toggle bit keeps its value.
    assert_toggle_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_en |=> $stable(toggle));

    // R8: a toggle change comes together with a raised flag.
    assert_toggle_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(toggle) |-> ovf_flag);

    // R9: the flag stays up without a clear.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    // R10: a count write lands on the next edge.
    assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count == $past(wr_data)));
endmodule

bind updown_reload_timer tmr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dir_en(dir_en),
    .dir_pin(dir_pin), .wr_cnt(wr_cnt), .wr_data(wr_data),
    .flag_clr(flag_clr), .count(count), .reload(reload),
    .ovf_flag(ovf_flag), .toggle(toggle)
);

// File: tb/updown_reload_timer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected states, a monitor compares.
module updown_reload_timer_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0, src_sel = 1'b1, dir_en = 1'b0, dir_pin = 1'b0;
    logic         cnt_pin = 1'b0, wr_cnt = 1'b0, wr_rld = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count, reload;
    logic         ovf_flag, toggle;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] q_cnt[$];
    logic         q_flg[$];
    logic         q_tgl[$];
    string        q_tag[$];

    always #2.5 clk = ~clk;

    updown_reload_timer #(.WIDTH(W), .PRESCALE(12), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
        .dir_en(dir_en), .dir_pin(dir_pin), .cnt_pin(cnt_pin),
        .wr_cnt(wr_cnt), .wr_rld(wr_rld), .wr_data(wr_data),
        .flag_clr(flag_clr), .count(count), .reload(reload),
        .ovf_flag(ovf_flag), .toggle(toggle)
    );

    // Monitor: pops each expected item and compares it with the outputs.
    initial begin
        forever begin
            logic [W-1:0] ec;
            logic ef, et;
            string tg;
            wait (q_cnt.size() != 0);
            ec = q_cnt.pop_front();
            ef = q_flg.pop_front();
            et = q_tgl.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (count !== ec || ovf_flag !== ef || toggle !== et) begin
                fails++;
                $display("FAIL %s: cnt=%h flag=%b tgl=%b, expected cnt=%h flag=%b tgl=%b",
                         tg, count, ovf_flag, toggle, ec, ef, et);
            end
        end
    end

    task automatic expect_state(input logic [W-1:0] c, input logic f,
                                input logic t, input string tag);
        q_cnt.push_back(c); q_flg.push_back(f); q_tgl.push_back(t); q_tag.push_back(tag);
        #0.1;
    endtask

    task automatic wr_reg(input bit to_cnt, input logic [W-1:0] d);
        @(negedge clk);
        wr_data = d;
        if (to_cnt) wr_cnt = 1'b1; else wr_rld = 1'b1;
        @(negedge clk);
        wr_cnt = 1'b0; wr_rld = 1'b0;
    endtask

    // One pin pulse; clr/wr drive the strobes in the cycle the step lands.
    task automatic pin_pulse(input bit clr, input bit wr, input logic [W-1:0] d);
        @(negedge clk); cnt_pin = 1'b1;
        @(negedge clk); cnt_pin = 1'b0;
        @(negedge clk);
        flag_clr = clr; wr_cnt = wr; wr_data = d;
        @(negedge clk);
        flag_clr = 1'b0; wr_cnt = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: cnt=%h, expected run to end", count);
        finish_run();
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state(8'h00, 1'b0, 1'b0, "R1 reset state");
        if (reload !== 8'h00) begin
            checks++; fails++;
            $display("FAIL R1: reload=%h expected 00", reload);
        end else checks++;

        wr_reg(1'b0, 8'h40);
        wr_reg(1'b1, 8'hFD);
        expect_state(8'hFD, 1'b0, 1'b0, "R10 count write");
        checks++;
        if (reload !== 8'h40) begin
            fails++; $display("FAIL R10: reload=%h expected 40", reload);
        end

        run_en = 1'b1; src_sel = 1'b1; dir_en = 1'b0; dir_pin = 1'b0;
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'hFE, 1'b0, 1'b0, "R3 pin step / R5 up with dir_pin low");
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'hFF, 1'b0, 1'b0, "R3 pin step");
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'h40, 1'b1, 1'b0, "R5 overflow reload, R8 no toggle");

        // R3: a held level counts once.
        @(negedge clk); cnt_pin = 1'b1;
        repeat (8) @(negedge clk);
        expect_state(8'h41, 1'b1, 1'b0, "R3 held pin counts once");
        cnt_pin = 1'b0;
        repeat (3) @(negedge clk);

        // R4: stopped timer ignores pin edges.
        run_en = 1'b0;
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'h41, 1'b1, 1'b0, "R4 run off holds count");
        run_en = 1'b1;

        clear_flag();
        expect_state(8'h41, 1'b0, 1'b0, "R9 clear flag");

        // R6: up/down mode counting up.
        dir_en = 1'b1; dir_pin = 1'b1;
        wr_reg(1'b1, 8'hFF);
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'h40, 1'b1, 1'b1, "R6 up overflow, R8 toggle");

        // R9: clear together with event keeps the flag.
        wr_reg(1'b1, 8'hFF);
        pin_pulse(1'b1, 1'b0, '0);
        expect_state(8'h40, 1'b1, 1'b0, "R9 clear with event keeps flag");

        // R7: down-count underflow at the reload value.
        clear_flag();
        dir_pin = 1'b0;
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'hFF, 1'b1, 1'b1, "R7 underflow loads all-ones");
        clear_flag();
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'hFE, 1'b0, 1'b1, "R7 down step");
        wr_reg(1'b1, 8'h42);
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'h41, 1'b0, 1'b1, "R7 down step");
        pin_pulse(1'b0, 1'b0, '0);
        expect_state(8'h40, 1'b0, 1'b1, "R7 down reaches reload");

        // R10: a write in the step cycle wins and raises no event.
        pin_pulse(1'b0, 1'b1, 8'h10);
        expect_state(8'h10, 1'b0, 1'b1, "R10 write beats step");

        // R2: internal divide-by-12 tick.
        run_en = 1'b0; src_sel = 1'b0; dir_en = 1'b0;
        wr_reg(1'b1, 8'h00);
        @(negedge clk); run_en = 1'b1;
        repeat (11) @(negedge clk);
        expect_state(8'h00, 1'b0, 1'b1, "R2 no step before 12 clocks");
        @(negedge clk);
        expect_state(8'h01, 1'b0, 1'b1, "R2 step at 12 clocks");
        repeat (11) @(negedge clk);
        expect_state(8'h01, 1'b0, 1'b1, "R2 hold between ticks");
        @(negedge clk);
        expect_state(8'h02, 1'b0, 1'b1, "R2 second tick");

        wait (q_cnt.size() == 0);
        #1;
        finish_run();
    end
endmodule